// File: doc/BRIEF.md
# Low-Side Fault Protection Controller

This block guards the three low-side switches of an inverter bridge. It watches three digitised conditions: the low-side supply, given as two comparator bits for the two undervoltage thresholds, an overcurrent comparator and an overtemperature comparator with two thresholds. When any of them reports a fault, it turns all low-side gate enables off together. It also pulls an active-low fault line low for at least a programmable number of clock cycles, or for as long as the fault lasts if that is longer.

An overcurrent trip is accepted only after the comparator has stayed high for a programmable qualification delay. A shorter trip is discarded. Overcurrent clears once the minimum width has run out. Undervoltage and overtemperature clear only when the minimum width has run out and the condition has cleared through its hysteresis band.

After any fault the gates do not pick up a PWM pulse that is already in progress. Each channel must first see its command low, and it then follows the next pulse. A sticky status vector records which sources have raised a fault, and each of its bits is cleared by a write-one pulse.

All comparator inputs pass through two-flop synchronisers. The PWM commands come from the same clock domain and gate the outputs without a register.

Top module: `lowside_guard`

## Requirements
- R1: Out of reset, all gate enables are 0 and `fault_n` is 0, and `status` is 0. `fault_n` rises on the third clock edge after `sup_above_on` goes high, with `sup_below_off` low. No status bit is set by this power-up hold.
- R2: When `sup_below_off` goes high, `fault_n` falls on the third clock edge after the change. While `fault_n` is 0, `gate_en` is 0 on every channel, whatever `pwm_in` is.
- R3: Once `fault_n` falls because of a fault event, it stays 0 for at least `FO_CYCLES` clock cycles.
- R4: An undervoltage fault releases on edge 3 + max(`FO_CYCLES`, T), where the event is at edge 3 and T is the number of cycles until `sup_above_on` is high with `sup_below_off` low. A supply inside the hysteresis band, with both bits low, keeps the fault active.
- R5: An overcurrent fault is raised only if `oc_trip` stays high for at least `OC_DELAY` consecutive cycles. `fault_n` then falls on edge 2 + `OC_DELAY` after the rise. A shorter trip leaves `fault_n` high and `status` unchanged.
- R6: An overcurrent fault holds `fault_n` low for exactly `FO_CYCLES` cycles, unless another source extends it.
- R7: An overtemperature fault is raised by `temp_over`. It releases only once `temp_below_rel` is high and `FO_CYCLES` have elapsed. A temperature between the two thresholds, with both bits low, keeps it active.
- R8: When a fault releases, `gate_en[i]` stays 0 while `pwm_in[i]` remains high. It follows `pwm_in[i]` again only after `pwm_in[i]` has been sampled low at a clock edge.
- R9: With no fault active and the channel re-armed, `gate_en` equals `pwm_in` in the same cycle, for every pattern of the three bits.
- R10: `status` bit 0 marks undervoltage, bit 1 overcurrent and bit 2 overtemperature. A bit is set on the edge at which its fault becomes active. It stays set until a cycle with the matching `status_clr` bit high, after which it reads 0. A set in the same cycle wins over the clear, and a clear bit does not affect the other status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwm_in | input | NCH | Low-side PWM commands, active high |
| sup_below_off | input | 1 | Supply is below the turn-off threshold (asynchronous) |
| sup_above_on | input | 1 | Supply is above the turn-on threshold (asynchronous) |
| oc_trip | input | 1 | Overcurrent comparator (asynchronous) |
| temp_over | input | 1 | Temperature is above the trip level (asynchronous) |
| temp_below_rel | input | 1 | Temperature is below the trip level minus the hysteresis (asynchronous) |
| status_clr | input | 3 | Write-one-to-clear pulse for each status bit |
| gate_en | output | NCH | Low-side gate enables |
| fault_n | output | 1 | Fault output, active low |
| status | output | 3 | Sticky fault sources {overtemp, overcurrent, undervoltage} |

## Verification
Each comparator input needs two edges to pass its synchroniser, and the fault latch takes a third edge. An undervoltage or overtemperature event therefore shows on `fault_n` after edge 3, and an overcurrent event after edge 2 + `OC_DELAY`. The release is due at edge 3 + max(`FO_CYCLES`, time the condition stays active), and `gate_en` follows `pwm_in` in the same cycle. The bench drives each stimulus one time unit after a rising edge and samples one time unit after each following edge. It numbers those edges from the stimulus, and it compares the first low edge and the count of low samples with these formulas. It sweeps the pulse and hold lengths across every boundary of the trip and release conditions.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  localparam int SRC_UV = 0;
  localparam int SRC_OC = 1;
  localparam int SRC_OT = 2;
  localparam int NSRC   = 3;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/lsg_sync.sv
module lsg_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/lsg_oc_qual.sv
module lsg_oc_qual #(
  parameter int DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic hold,
  output logic fire
);
  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q;
  logic at_last;

  assign at_last = (cnt_q == LAST);
  assign fire    = trip & ~hold & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (hold || !trip)   cnt_q <= '0;
    else if (!at_last)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lsg_fault_core.sv
module lsg_fault_core
  import lsg_pkg::*;
#(
  parameter int FO_CYCLES = 20
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     s_low,
  input  logic     s_on,
  input  logic     oc_fire,
  input  logic     s_hot,
  input  logic     s_cool,
  input  src_vec_t clr,
  output src_vec_t active,
  output logic     fault,
  output src_vec_t status
);
  localparam int FW = (FO_CYCLES > 1) ? $clog2(FO_CYCLES) : 1;
  localparam logic [FW-1:0] FO_LOAD = FW'(FO_CYCLES - 1);

  src_vec_t act_q, act_d, set_v, stat_q;
  logic [FW-1:0] fo_q;
  logic fo_zero, new_evt;

  assign fo_zero = (fo_q == '0);

  always_comb begin
    set_v         = '0;
    set_v[SRC_UV] = s_low;
    set_v[SRC_OC] = oc_fire;
    set_v[SRC_OT] = s_hot;
    act_d         = '0;
    act_d[SRC_UV] = s_low   | (act_q[SRC_UV] & ~(s_on & fo_zero));
    act_d[SRC_OC] = oc_fire | (act_q[SRC_OC] & ~fo_zero);
    act_d[SRC_OT] = s_hot   | (act_q[SRC_OT] & ~(s_cool & fo_zero));
  end

  assign new_evt = |(set_v & ~act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q         <= '0;
      act_q[SRC_UV] <= 1'b1;
      fo_q          <= '0;
      stat_q        <= '0;
    end else begin
      act_q  <= act_d;
      stat_q <= (stat_q & ~clr) | (set_v & ~act_q);
      if (new_evt)       fo_q <= FO_LOAD;
      else if (!fo_zero) fo_q <= fo_q - 1'b1;
    end
  end

  assign active = act_q;
  assign fault  = |act_q;
  assign status = stat_q;
endmodule

// File: rtl/lsg_gate_arm.sv
module lsg_gate_arm #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fault,
  input  logic [NCH-1:0] pwm,
  output logic [NCH-1:0] gate_en
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (fault) armed_q <= 1'b0;
      else if (!pwm[i]) armed_q <= 1'b1;
    end
    assign gate_en[i] = pwm[i] & armed_q & ~fault;
  end
endmodule

// File: rtl/lowside_guard.sv
module lowside_guard
  import lsg_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int FO_CYCLES   = 20,
  parameter int OC_DELAY    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pwm_in,
  input  logic           sup_below_off,
  input  logic           sup_above_on,
  input  logic           oc_trip,
  input  logic           temp_over,
  input  logic           temp_below_rel,
  input  logic [2:0]     status_clr,
  output logic [NCH-1:0] gate_en,
  output logic           fault_n,
  output logic [2:0]     status
);
  localparam int NIN = 5;

  logic [NIN-1:0] raw, syn;
  logic oc_fire, fault;
  src_vec_t active, stat;

  assign raw = {temp_below_rel, temp_over, oc_trip, sup_above_on, sup_below_off};

  lsg_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  lsg_oc_qual #(.DLY(OC_DELAY)) u_ocq (
    .clk(clk), .rst_n(rst_n), .trip(syn[2]), .hold(active[SRC_OC]), .fire(oc_fire)
  );

  lsg_fault_core #(.FO_CYCLES(FO_CYCLES)) u_core (
    .clk(clk), .rst_n(rst_n),
    .s_low(syn[0]), .s_on(syn[1]), .oc_fire(oc_fire),
    .s_hot(syn[3]), .s_cool(syn[4]),
    .clr(status_clr), .active(active), .fault(fault), .status(stat)
  );

  lsg_gate_arm #(.NCH(NCH)) u_arm (
    .clk(clk), .rst_n(rst_n), .fault(fault), .pwm(pwm_in), .gate_en(gate_en)
  );

  assign fault_n = ~fault;
  assign status  = stat;
endmodule

// File: rtl/lowside_guard_chk.sv
module lowside_guard_chk #(
  parameter int NCH       = 3,
  parameter int FO_CYCLES = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     status_clr,
  input logic [NCH-1:0] gate_en,
  input logic           fault_n,
  input logic [2:0]     status
);
  logic [15:0] lowc_q;
  logic seen_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowc_q    <= '0;
      seen_hi_q <= 1'b0;
    end else begin
      if (fault_n) begin
        lowc_q    <= '0;
        seen_hi_q <= 1'b1;
      end else if (lowc_q != 16'hFFFF) begin
        lowc_q <= lowc_q + 1'b1;
      end
    end
  end

  a_r2_gates_off_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (gate_en == '0));

  a_r3_min_fault_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_n) && seen_hi_q) |-> (lowc_q >= 16'(FO_CYCLES)));

  a_r8_no_gate_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> (gate_en == '0));

  for (genvar i = 0; i < 3; i++) begin : g_st
    a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !status_clr[i]) |=> status[i]);
    a_r10_status_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> !fault_n);
  end
endmodule

bind lowside_guard lowside_guard_chk #(.NCH(NCH), .FO_CYCLES(FO_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_clr(status_clr),
  .gate_en(gate_en), .fault_n(fault_n), .status(status)
);

// File: tb/sim_lowside_guard.sv
`timescale 1ns/1ps
module sim_lowside_guard;
  localparam int NCH = 3;
  localparam int FO  = 6;
  localparam int D   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] pwm_in = '0;
  logic sup_below_off = 1'b1, sup_above_on = 1'b0;
  logic oc_trip = 1'b0, temp_over = 1'b0, temp_below_rel = 1'b1;
  logic [2:0] status_clr = '0;
  logic [NCH-1:0] gate_en;
  logic fault_n;
  logic [2:0] status;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lowside_guard #(.NCH(NCH), .FO_CYCLES(FO), .OC_DELAY(D), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .sup_below_off(sup_below_off), .sup_above_on(sup_above_on),
    .oc_trip(oc_trip), .temp_over(temp_over), .temp_below_rel(temp_below_rel),
    .status_clr(status_clr), .gate_en(gate_en), .fault_n(fault_n), .status(status)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic rearm_check(input string tag);
    check({tag, " R8 gate held after release"}, int'(gate_en), 0);
    pwm_in = '0;
    tick();
    pwm_in = '1;
    tick();
    check({tag, " R8 gate follows next pulse"}, int'(gate_en), 7);
  endtask

  task automatic clear_status();
    status_clr = 3'b111;
    tick();
    status_clr = '0;
    check("R10 status cleared", int'(status), 0);
  endtask

  task automatic oc_pulse(input int len);
    int first = 0, cnt = 0, leak = 0;
    oc_trip = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      tick();
      if (k == len) oc_trip = 1'b0;
      if (!fault_n) begin
        cnt++;
        if (first == 0) first = k;
        if (gate_en != '0) leak++;
      end
    end
    check($sformatf("R5 oc len=%0d first low edge", len), first, (len >= D) ? 2 + D : 0);
    check($sformatf("R6 oc len=%0d low width", len), cnt, (len >= D) ? FO : 0);
    check("R2 gates off during oc fault", leak, 0);
    check($sformatf("R10 status after oc len=%0d", len), int'(status), (len >= D) ? 2 : 0);
    if (len >= D) rearm_check("oc");
    clear_status();
  endtask

  task automatic uv_drop(input int len, input int mid);
    int first = 0, cnt = 0, leak = 0;
    sup_above_on = 1'b0;
    sup_below_off = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      tick();
      if (k == len) sup_below_off = 1'b0;
      if (k == len + mid) sup_above_on = 1'b1;
      if (!fault_n) begin
        cnt++;
        if (first == 0) first = k;
        if (gate_en != '0) leak++;
      end
    end
    check($sformatf("R2 uv len=%0d first low edge", len), first, 3);
    check($sformatf("R4 uv len=%0d mid=%0d width", len, mid), cnt, maxi(len + mid, FO));
    check("R2 gates off during uv fault", leak, 0);
    check("R10 status after uv", int'(status), 1);
    rearm_check("uv");
    status_clr = 3'b110;
    tick();
    status_clr = '0;
    check("R10 other clear bits leave uv bit", int'(status), 1);
    clear_status();
  endtask

  task automatic ot_event(input int len, input int mid);
    int first = 0, cnt = 0;
    temp_below_rel = 1'b0;
    temp_over = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      tick();
      if (k == len) temp_over = 1'b0;
      if (k == len + mid) temp_below_rel = 1'b1;
      if (!fault_n) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
    check($sformatf("R7 ot len=%0d first low edge", len), first, 3);
    check($sformatf("R7 ot len=%0d mid=%0d width", len, mid), cnt, maxi(len + mid, FO));
    check("R10 status after ot", int'(status), 4);
    rearm_check("ot");
    clear_status();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rel;
    pwm_in = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    // R1 power-up hold
    check("R1 fault held at power-up", int'(fault_n), 0);
    check("R1 gates off at power-up", int'(gate_en), 0);
    check("R1 status zero at power-up", int'(status), 0);
    sup_below_off = 1'b0;
    sup_above_on = 1'b1;
    rel = 0;
    for (int k = 1; k <= 10; k++) begin
      tick();
      if (fault_n && rel == 0) rel = k;
    end
    check("R1 release edge after supply good", rel, 3);
    check("R1 no status from power-up", int'(status), 0);
    check("R8 gate held after power-up", int'(gate_en), 0);

    // R9 pass-through sweep
    pwm_in = '0;
    tick();
    for (int p = 0; p < 8; p++) begin
      pwm_in = NCH'(p);
      #1;
      check($sformatf("R9 pass-through pattern %0d", p), int'(gate_en), p);
      tick();
    end
    pwm_in = '1;
    tick();

    for (int len = 1; len <= D + 3; len++) oc_pulse(len);
    for (int len = 1; len <= FO + 3; len++) uv_drop(len, 0);
    uv_drop(2, FO + 2);
    uv_drop(FO, 3);
    for (int len = 1; len <= 4; len++) begin
      ot_event(len, 0);
      ot_event(len, 3);
    end
    ot_event(2, FO + 2);

    // R10 set wins over clear in the same cycle
    oc_trip = 1'b1;
    for (int k = 1; k <= D + 1; k++) begin
      tick();
      if (k == D + 1) status_clr = 3'b010;
    end
    tick();
    status_clr = '0;
    oc_trip = 1'b0;
    check("R10 set wins over clear", int'(status[1]), 1);
    repeat (FO + 4) tick();
    clear_status();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule